// File: doc/BRIEF.md
# Flag-Controlled Sixteen-Bit ALU

This block is a purely combinational arithmetic logic unit. It takes two 16-bit operands, `x_i` and `y_i`, and a 6-bit control word `fn_i`, and produces a 16-bit result together with a zero flag and a sign flag.

The control word is not an enumerated opcode. Each of its bits switches one elementary step on or off:

- clear the first operand;
- invert the first operand;
- clear the second operand;
- invert the second operand;
- choose sum or bitwise AND;
- invert the output.

Eighteen fixed settings of these switches give the usual accumulator-style functions: constants, pass-through, complement, negation, increment, decrement, add, subtract, AND and OR. The choice of whether the second operand comes from an address register or from memory data is made upstream of this block.

Top module: `flag_alu16`

## Requirements
- R1: For any code, the steps run in a fixed order. fn_i[5] clears x, then fn_i[4] inverts it. fn_i[3] clears y, then fn_i[2] inverts it. fn_i[1]=1 selects the sum of the conditioned operands and fn_i[1]=0 selects their bitwise AND. Finally fn_i[0] inverts the output.
- R2: Codes 101010, 111111 and 111010 give the constants 0, 1 and -1 (all ones) for any operands.
- R3: Code 001100 gives x and code 110000 gives y. Code 001101 gives ~x and code 110001 gives ~y.
- R4: Code 001111 gives -x and code 110011 gives -y, in two's complement.
- R5: Codes 011111 and 110111 give x+1 and y+1. Codes 001110 and 110010 give x-1 and y-1.
- R6: Code 000010 gives x+y, code 010011 gives x-y and code 000111 gives y-x. All arithmetic is modulo 2^16 and any carry-out is dropped.
- R7: Code 000000 gives x AND y, and code 010101 gives x OR y.
- R8: zr_o is 1 exactly when res_o is all zeros.
- R9: ng_o always equals res_o[15].
- R10: The block holds no state. Outputs follow a change on any input with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | 16 | First operand (data accumulator side) |
| y_i | input | 16 | Second operand (address or memory side) |
| fn_i | input | 6 | Step switches, bit 5 down to bit 0 as in R1 |
| res_o | output | 16 | Result |
| zr_o | output | 1 | Result-is-zero flag |
| ng_o | output | 1 | Result sign flag |

## Verification
The hardest results to reach are the ones that only come out right when the step order is exact. Negation and subtraction are built as invert, add, invert, so swapping the clear and invert steps, or using the wrong adder input, hides itself for most operand values. The stimulus therefore sweeps all 64 codes, not only the 18 named ones, over operands chosen to expose ordering and carry slips: zero, all ones, 0x8000, 0x7FFF and pseudo-random words. Wrap-around cases are driven on purpose, such as 0xFFFF+1 and 0x8000-1, so that the dropped carry and the flag edges are reached directly.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  localparam int unsigned FN_W = 6;

  // field order matches fn_i bit 5 down to bit 0
  typedef struct packed {
    logic clr_a;
    logic inv_a;
    logic clr_b;
    logic inv_b;
    logic sum;
    logic inv_out;
  } fn_t;
endpackage

// File: rtl/alu_opnd_cond.sv
module alu_opnd_cond #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] opnd_i,
  input  logic         clr_i,
  input  logic         inv_i,
  output logic [W-1:0] opnd_o
);
  logic [W-1:0] cleared;

  always_comb begin
    cleared = clr_i ? '0 : opnd_i;
    opnd_o  = inv_i ? ~cleared : cleared;
  end
endmodule

// File: rtl/alu_func_unit.sv
module alu_func_unit #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sum_i,
  input  logic         inv_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] core;

  always_comb begin
    // carry-out intentionally dropped: W-bit wrap
    core  = sum_i ? (a_i + b_i) : (a_i & b_i);
    res_o = inv_i ? ~core : core;
  end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] res_i,
  output logic         zr_o,
  output logic         ng_o
);
  assign zr_o = ~|res_i;
  assign ng_o = res_i[W-1];
endmodule

// File: rtl/flag_alu16.sv
module flag_alu16 #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]                   x_i,
  input  logic [W-1:0]                   y_i,
  input  logic [flag_alu_pkg::FN_W-1:0]  fn_i,
  output logic [W-1:0]                   res_o,
  output logic                           zr_o,
  output logic                           ng_o
);
  import flag_alu_pkg::*;

  localparam int unsigned N_OPND = 2;

  fn_t          fn;
  logic [W-1:0] opnd_raw  [N_OPND];
  logic [W-1:0] opnd_cond [N_OPND];
  logic         opnd_clr  [N_OPND];
  logic         opnd_inv  [N_OPND];

  assign fn          = fn_t'(fn_i);
  assign opnd_raw[0] = x_i;
  assign opnd_raw[1] = y_i;
  assign opnd_clr[0] = fn.clr_a;
  assign opnd_inv[0] = fn.inv_a;
  assign opnd_clr[1] = fn.clr_b;
  assign opnd_inv[1] = fn.inv_b;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    alu_opnd_cond #(.W(W)) u_cond (
      .opnd_i (opnd_raw[g]),
      .clr_i  (opnd_clr[g]),
      .inv_i  (opnd_inv[g]),
      .opnd_o (opnd_cond[g])
    );
  end

  alu_func_unit #(.W(W)) u_func (
    .a_i   (opnd_cond[0]),
    .b_i   (opnd_cond[1]),
    .sum_i (fn.sum),
    .inv_i (fn.inv_out),
    .res_o (res_o)
  );

  alu_flag_gen #(.W(W)) u_flags (
    .res_i (res_o),
    .zr_o  (zr_o),
    .ng_o  (ng_o)
  );
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int unsigned W = 16
) (
  input logic [W-1:0] x_i,
  input logic [W-1:0] y_i,
  input logic [5:0]   fn_i,
  input logic [W-1:0] res_o,
  input logic         zr_o,
  input logic         ng_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    p_zero_flag_r8: assert (zr_o == (res_o == '0))
      else $error("zr_o disagrees with res_o");
    p_sign_flag_r9: assert (ng_o == res_o[W-1])
      else $error("ng_o disagrees with res_o msb");
    if (fn_i == 6'b101010) begin
      p_const_zero_r2: assert (res_o == '0)
        else $error("code 101010 not zero");
    end
    if (fn_i == 6'b111111) begin
      p_const_one_r2: assert (res_o == ONE)
        else $error("code 111111 not one");
    end
    if (fn_i == 6'b001100) begin
      p_pass_x_r3: assert (res_o == x_i)
        else $error("code 001100 not x");
    end
    if (fn_i == 6'b001111) begin
      p_neg_x_r4: assert (res_o == W'(-x_i))
        else $error("code 001111 not -x");
    end
    if (fn_i == 6'b010011) begin
      p_sub_xy_r6: assert (res_o == W'(x_i - y_i))
        else $error("code 010011 not x-y");
    end
    if (fn_i == 6'b010101) begin
      p_or_r7: assert (res_o == (x_i | y_i))
        else $error("code 010101 not x|y");
    end
  end
endmodule

bind flag_alu16 flag_alu_chk #(.W(W)) u_chk (
  .x_i   (x_i),
  .y_i   (y_i),
  .fn_i  (fn_i),
  .res_o (res_o),
  .zr_o  (zr_o),
  .ng_o  (ng_o)
);

// File: tb/sim_flag_alu16.sv
module sim_flag_alu16;
  logic        clk;
  logic        rst_ni;
  logic [15:0] x, y, res;
  logic [5:0]  fn;
  logic        zr, ng;
  int          total = 0;
  int          bad   = 0;
  logic [15:0] lfsr  = 16'hACE1;

  flag_alu16 u0 (
    .x_i   (x),
    .y_i   (y),
    .fn_i  (fn),
    .res_o (res),
    .zr_o  (zr),
    .ng_o  (ng)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] next_rand(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // R2..R7 reference: function meaning per listed code
  function automatic logic [15:0] listed_ref(input logic [5:0] c,
                                             input logic [15:0] a, b);
    case (c)
      6'b101010: return 16'h0000;
      6'b111111: return 16'h0001;
      6'b111010: return 16'hFFFF;
      6'b001100: return a;
      6'b110000: return b;
      6'b001101: return ~a;
      6'b110001: return ~b;
      6'b001111: return 16'(0 - a);
      6'b110011: return 16'(0 - b);
      6'b011111: return 16'(a + 1);
      6'b110111: return 16'(b + 1);
      6'b001110: return 16'(a - 1);
      6'b110010: return 16'(b - 1);
      6'b000010: return 16'(a + b);
      6'b010011: return 16'(a - b);
      6'b000111: return 16'(b - a);
      6'b000000: return a & b;
      default:   return a | b;
    endcase
  endfunction

  // R1 reference: the stated sequence of steps
  function automatic logic [15:0] step_ref(input logic [5:0] c,
                                           input logic [15:0] a, b);
    logic [15:0] p, q, r;
    p = c[5] ? 16'h0 : a;
    p = c[4] ? ~p : p;
    q = c[3] ? 16'h0 : b;
    q = c[2] ? ~q : q;
    r = c[1] ? 16'(p + q) : (p & q);
    return c[0] ? ~r : r;
  endfunction

  task automatic check(input string req, input logic [15:0] got, exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s fn=%b x=%h y=%h actual=%h expected=%h",
               req, fn, x, y, got, exp);
    end
  endtask

  task automatic check_flags(input string tag);
    check({"R8 ", tag}, {15'h0, zr}, {15'h0, res === 16'h0});
    check({"R9 ", tag}, {15'h0, ng}, {15'h0, res[15]});
  endtask

  task automatic apply(input logic [5:0] c, input logic [15:0] a, b);
    @(posedge clk);
    fn = c; x = a; y = b;
    @(negedge clk);
  endtask

  task automatic t_initial();
    apply(6'b000000, 16'h0, 16'h0);
    check("R7 initial", res, 16'h0);
    check_flags("initial");
  endtask

  task automatic t_listed();
    logic [5:0] codes [18];
    codes = '{6'b101010, 6'b111111, 6'b111010, 6'b001100, 6'b110000,
              6'b001101, 6'b110001, 6'b001111, 6'b110011, 6'b011111,
              6'b110111, 6'b001110, 6'b110010, 6'b000010, 6'b010011,
              6'b000111, 6'b000000, 6'b010101};
    for (int p = 0; p < 12; p++) begin
      logic [15:0] a, b;
      case (p)
        0: begin a = 16'h0000; b = 16'h0000; end
        1: begin a = 16'hFFFF; b = 16'hFFFF; end
        2: begin a = 16'h8000; b = 16'h7FFF; end
        3: begin a = 16'h0001; b = 16'hFFFF; end
        default: begin
          lfsr = next_rand(lfsr); a = lfsr;
          lfsr = next_rand(lfsr); b = lfsr;
        end
      endcase
      for (int k = 0; k < 18; k++) begin
        apply(codes[k], a, b);
        check("R2-7 listed", res, listed_ref(codes[k], a, b));
        check_flags("listed");
      end
    end
  endtask

  task automatic t_sweep();
    for (int p = 0; p < 8; p++) begin
      lfsr = next_rand(lfsr);
      for (int c = 0; c < 64; c++) begin
        apply(6'(c), lfsr, ~{lfsr[7:0], lfsr[15:8]});
        check("R1 sweep", res, step_ref(6'(c), x, y));
      end
    end
  endtask

  task automatic t_wrap();
    apply(6'b000010, 16'hFFFF, 16'h0001);
    check("R6 carry dropped", res, 16'h0000);
    check_flags("wrap0");
    apply(6'b001110, 16'h8000, 16'h1234);
    check("R5 x-1 wrap", res, 16'h7FFF);
    check_flags("wrap1");
    apply(6'b110111, 16'h0000, 16'h7FFF);
    check("R5 y+1 to sign", res, 16'h8000);
    check_flags("wrap2");
    apply(6'b001111, 16'h8000, 16'h0000);
    check("R4 -min", res, 16'h8000);
    apply(6'b000111, 16'h0005, 16'h0003);
    check("R6 y-x", res, 16'hFFFE);
    check_flags("wrap3");
  endtask

  task automatic t_no_clock();
    // R10: change inputs mid-phase, no edge in between
    @(negedge clk);
    fn = 6'b000010; x = 16'h0010; y = 16'h0020;
    #2;
    check("R10 async", res, 16'h0030);
    y = 16'h0100;
    #2;
    check("R10 async", res, 16'h0110);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    fn = '0; x = '0; y = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_initial();
    t_listed();
    t_sweep();
    t_wrap();
    t_no_clock();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule